// File: doc/BRIEF.md
# Load Element Width and Saturation Formatter

This block takes the raw bytes returned for a single load element and turns them into the value that belongs in the destination element. The caller gives, with each element, the width of the memory access, the width of the destination element, a byte-reverse flag taken from the opcode, the processor's little-endian flag, a saturation enable and a signed/unsigned select. The formatted element comes out right-justified in a 64-bit word. Placing the element into register lanes and fetching memory are both handled elsewhere.

The work is done in a fixed order. First, the bytes of the access are reversed when the byte-reverse flag and the little-endian flag are equal. Second, the value is extended from the access width. Third, it is either truncated to the destination width or, with saturation on, clamped to it. Both ends of the block use valid/ready handshakes. An element moves across the input when `in_valid` and `in_ready` are both high at a clock edge, and a result leaves when `out_valid` and `out_ready` are both high. While `out_ready` is low, a pending result stays in place unchanged, and `in_ready` falls once every stage holds an element. No element is dropped or duplicated. The `PIPE_STAGES` parameter sets the latency to one or two cycles.

Top module: `ld_elem_fmt`

## Requirements
- R1: The bytes inside the access width are reversed (byte k becomes byte n-1-k of an n-byte access) exactly when `in_brev` equals `in_le`. Otherwise they keep their order. Width codes on `in_opw` and `in_dstw` are 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits.
- R2: Input data bits at or above the access width have no effect on the result.
- R3: With `in_sat` low, the result is the byte-ordered access value, zero-extended or truncated to the destination width, whatever the value of `in_sgn`.
- R4: With `in_sat` high and `in_sgn` = 1, the value is sign-extended from the access width and clamped to the most negative and most positive two's-complement values of the destination width.
- R5: With `in_sat` high and `in_sgn` = 0, the value is treated as unsigned and clamped to the all-ones value of the destination width.
- R6: With saturation on and the destination at least as wide as the access, the result is only the extension of the value, with no clamping.
- R7: Output bits at and above the destination width are zero.
- R8: With `out_ready` held high, an element accepted at one edge appears on `out_data` with `out_valid` exactly `PIPE_STAGES` edges later.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady. `in_ready` is low only while an output is pending. Results leave in the order they were accepted.
- R10: During reset and right after it, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Block can take an element |
| in_data | input | 64 | Raw memory bytes, byte 0 in bits 7:0 |
| in_opw | input | 2 | Access width code |
| in_dstw | input | 2 | Destination width code |
| in_brev | input | 1 | Byte-reverse opcode flag |
| in_le | input | 1 | Processor little-endian flag |
| in_sat | input | 1 | Saturation enable |
| in_sgn | input | 1 | 1 = signed saturation, 0 = unsigned |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Formatted element, right-justified |

## Verification
The bench builds the block with `PIPE_STAGES` = 2. This puts a register between the swap/extend step and the clamp step, so a stalled output can back up into the first stage. That setup lets the bench show three things: `in_ready` falling only when both stages are occupied, results leaving in order after the stall is released, and the two-edge latency. The vector table covers every swap decision and every direction of width change. It also covers both saturation flavours at each clamp limit.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;
  localparam int DW = 64;
  localparam int NB = DW / 8;

  typedef enum logic [1:0] {W8 = 2'd0, W16 = 2'd1, W32 = 2'd2, W64 = 2'd3} wcode_e;

  typedef struct packed {
    logic [DW-1:0] val;
    wcode_e        dst;
    logic          sat;
    logic          sgn;
  } mid_t;

  // all-ones mask covering the width named by the code
  function automatic logic [DW-1:0] wmask(input wcode_e w);
    case (w)
      W8:      wmask = DW'(64'hFF);
      W16:     wmask = DW'(64'hFFFF);
      W32:     wmask = DW'(64'hFFFF_FFFF);
      default: wmask = '1;
    endcase
  endfunction
endpackage

// File: rtl/ldfmt_swap.sv
module ldfmt_swap
  import ldfmt_pkg::*;
(
  input  logic [DW-1:0] raw,
  input  wcode_e        opw,
  input  logic          swap_en,
  output logic [DW-1:0] ordered
);
  int nbytes;
  assign nbytes = 1 << opw;

  // keep only bytes inside the access; mirror them when swapping
  always_comb begin
    ordered = '0;
    for (int k = 0; k < NB; k++) begin
      if (k < nbytes) begin
        if (swap_en) ordered[k*8 +: 8] = raw[(nbytes-1-k)*8 +: 8];
        else         ordered[k*8 +: 8] = raw[k*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/ldfmt_ext.sv
module ldfmt_ext
  import ldfmt_pkg::*;
(
  input  logic [DW-1:0] val,
  input  wcode_e        opw,
  input  logic          sext,
  output logic [DW-1:0] ext
);
  logic [DW-1:0] omask;
  logic          msb;

  assign omask = wmask(opw);
  assign msb   = val[(8 << opw) - 1];
  assign ext   = (sext && msb) ? (val | ~omask) : (val & omask);
endmodule

// File: rtl/ldfmt_clamp.sv
module ldfmt_clamp
  import ldfmt_pkg::*;
(
  input  logic [DW-1:0] val,
  input  wcode_e        dst,
  input  logic          sat,
  input  logic          sgn,
  output logic [DW-1:0] res
);
  logic [DW-1:0] dmask, smax, smin, r;

  assign dmask = wmask(dst);
  assign smax  = dmask >> 1;
  assign smin  = ~smax;

  always_comb begin
    r = val;
    if (sat && dst != W64) begin
      if (sgn) begin
        if ($signed(val) > $signed(smax))      r = smax;
        else if ($signed(val) < $signed(smin)) r = smin;
      end else if (val > dmask) begin
        r = dmask;
      end
    end
    res = r & dmask;
  end
endmodule

// File: rtl/ldfmt_slice.sv
module ldfmt_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         v_q;
  logic [W-1:0] d_q;

  assign up_ready = !v_q || dn_ready;
  assign dn_valid = v_q;
  assign dn_data  = d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        v_q <= 1'b0;
    else if (up_ready) v_q <= up_valid;
  end

  always_ff @(posedge clk) begin
    if (up_ready && up_valid) d_q <= up_data;
  end
endmodule

// File: rtl/ld_elem_fmt.sv
module ld_elem_fmt
  import ldfmt_pkg::*;
#(
  parameter int PIPE_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [63:0]   in_data,
  input  logic [1:0]    in_opw,
  input  logic [1:0]    in_dstw,
  input  logic          in_brev,
  input  logic          in_le,
  input  logic          in_sat,
  input  logic          in_sgn,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [63:0]   out_data
);
  localparam int MW = $bits(mid_t);

  logic [DW-1:0] sw_data, ext_data, fmt_data;
  logic          swap_en;
  mid_t          a_d, mid_q;
  logic          mid_valid, mid_ready;

  // reverse when opcode flag and endianness agree
  assign swap_en = ~(in_brev ^ in_le);

  ldfmt_swap u_swap (
    .raw(in_data), .opw(wcode_e'(in_opw)), .swap_en(swap_en), .ordered(sw_data)
  );

  ldfmt_ext u_ext (
    .val(sw_data), .opw(wcode_e'(in_opw)), .sext(in_sat && in_sgn), .ext(ext_data)
  );

  assign a_d = '{val: ext_data, dst: wcode_e'(in_dstw), sat: in_sat, sgn: in_sgn};

  generate
    if (PIPE_STAGES >= 2) begin : g_stage_a
      logic [MW-1:0] a_bits;
      ldfmt_slice #(.W(MW)) u_sl_a (
        .clk(clk), .rst_n(rst_n),
        .up_valid(in_valid), .up_ready(in_ready), .up_data(a_d),
        .dn_valid(mid_valid), .dn_ready(mid_ready), .dn_data(a_bits)
      );
      assign mid_q = mid_t'(a_bits);
    end else begin : g_no_stage_a
      assign mid_valid = in_valid;
      assign in_ready  = mid_ready;
      assign mid_q     = a_d;
    end
  endgenerate

  ldfmt_clamp u_clamp (
    .val(mid_q.val), .dst(mid_q.dst), .sat(mid_q.sat), .sgn(mid_q.sgn), .res(fmt_data)
  );

  ldfmt_slice #(.W(DW)) u_sl_b (
    .clk(clk), .rst_n(rst_n),
    .up_valid(mid_valid), .up_ready(mid_ready), .up_data(fmt_data),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(out_data)
  );
endmodule

// File: rtl/ld_elem_fmt_chk.sv
module ld_elem_fmt_chk
  import ldfmt_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [1:0]  in_opw,
  input logic [63:0] sw_data,
  input logic        mid_valid,
  input logic [1:0]  mid_dst,
  input logic [63:0] fmt_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data
);
  // R10
  rst_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9
  full_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);

  // R2
  swap_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (sw_data & ~wmask(wcode_e'(in_opw))) == '0);

  // R7
  dst_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid_valid |-> (fmt_data & ~wmask(wcode_e'(mid_dst))) == '0);
endmodule

bind ld_elem_fmt ld_elem_fmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_opw(in_opw), .sw_data(sw_data), .mid_valid(mid_valid),
  .mid_dst(mid_q.dst), .fmt_data(fmt_data), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/ld_elem_fmt_tb_top.sv
module ld_elem_fmt_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [63:0] d;
    logic [1:0]  ow, dw;
    logic        br, le, sat, sg;
    logic [63:0] exp;
  } vec_t;

  // width codes: 0=8 1=16 2=32 3=64; swap when br == le
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{64'hFFFF_FFFF_FFFF_FF80, 2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 64'h80},                 // R2 R3
    '{64'hFFFF_FFFF_FFFF_FF80, 2'd0, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FF80}, // R6
    '{64'hAAAA_AAAA_AAAA_1234, 2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 64'h3412},               // R1
    '{64'hAAAA_AAAA_AAAA_1234, 2'd1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 64'h3412},               // R1
    '{64'hAAAA_AAAA_AAAA_1234, 2'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 64'h1234},               // R1
    '{64'h0102_0304_0506_0708, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0807_0605_0403_0201}, // R1
    '{64'h1122_3344_AABB_CCDD, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 64'hDD},                 // R3 R7
    '{64'h0000_0000_7FFF_0000, 2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 64'h7FFF},               // R4
    '{64'h0000_0000_8000_0000, 2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 64'h8000},               // R4 R7
    '{64'h0000_0000_FFFF_FF85, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 64'h85},                 // R4
    '{64'h0000_0000_FFFF_FF85, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 64'hFF},                 // R5
    '{64'h0000_0000_0000_0100, 2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 64'hFF},                 // R5
    '{64'h8000_0000_0000_0000, 2'd3, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 64'h8000_0000},          // R4
    '{64'hFFFF_FFFF_0000_0000, 2'd3, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 64'hFFFF_FFFF},          // R5
    '{64'h0000_0000_0000_FF80, 2'd1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 64'hFFFF_FF80},          // R6 R7
    '{64'h0000_0000_0000_8001, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 64'h01},                 // R3
    '{64'h1122_3344_5566_7788, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 64'h8000},               // R1 R4
    '{64'h0000_0000_0000_0080, 2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 64'h80}                  // R3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [1:0]  in_opw = '0, in_dstw = '0;
  logic        in_brev = 1'b0, in_le = 1'b1, in_sat = 1'b0, in_sgn = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ld_elem_fmt #(.PIPE_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_opw(in_opw), .in_dstw(in_dstw), .in_brev(in_brev),
    .in_le(in_le), .in_sat(in_sat), .in_sgn(in_sgn), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_data = v.d; in_opw = v.ow; in_dstw = v.dw; in_brev = v.br;
    in_le = v.le; in_sat = v.sat; in_sgn = v.sg; in_valid = 1'b1;
  endtask

  task automatic simple(input logic [63:0] d);
    vec_t v;
    v = '{d, 2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0};
    drive(v);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 out_valid after reset", 64'(out_valid), 64'd0);
    chk("R10 in_ready after reset", 64'(in_ready), 64'd1);

    // table walk: R1-style checks with latency R8
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R8 no early output vec %0d", i), 64'(out_valid), 64'd0);
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R8 valid vec %0d", i), 64'(out_valid), 64'd1);
      chk($sformatf("R1-R7 table vec %0d", i), out_data, VECS[i].exp);
    end

    // back-pressure, R9
    @(negedge clk);
    out_ready = 1'b0;
    simple(64'h11);
    @(posedge clk);
    @(negedge clk);
    simple(64'h22);
    @(posedge clk);
    @(negedge clk);
    simple(64'h33);
    chk("R9 in_ready low when full", 64'(in_ready), 64'd0);
    chk("R9 first result pending", out_data, 64'h11);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 valid held while stalled", 64'(out_valid), 64'd1);
    chk("R9 data held while stalled", out_data, 64'h11);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 order second", out_data, 64'h22);
    @(posedge clk);
    @(negedge clk);
    chk("R9 order third", out_data, 64'h33);
    chk("R9 third valid", 64'(out_valid), 64'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R9 drained", 64'(out_valid), 64'd0);

    // reset mid-flight clears output, R10
    simple(64'h44);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset flushes", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 empty after reset", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule